// File: doc/BRIEF.md
# Phase-Interleaved Fetch and Data Memory Port

This block is the memory-access front end of a small processor core. It holds the program counter and fetches one instruction word per instruction from one of three regions chosen by the byte address in the program counter. The low region is a two-port register RAM, the middle region is a single-port 512-word lookup RAM, and everything above goes out as a request to an external hub memory over a request/valid handshake.

The core runs on a two-clock rhythm. The first clock (the fetch slot, state `PH_GO`) reads the instruction. The second clock (the operand slot, state `PH_OPND`) reads the source operand from the register RAM and carries any lookup-RAM data read or write. Because lookup-RAM fetches are confined to the fetch slot and lookup-RAM data accesses to the operand slot, code can run from the lookup RAM while the same RAM is read and written as data, with no arbitration and no stall. A lookup-RAM data read adds one clock (state `PH_RDX`). A hub fetch waits in state `PH_HUB` until the hub answers. The transitions are: `PH_GO`→`PH_HUB` for a hub address, otherwise `PH_GO`→`PH_OPND`; `PH_HUB`→`PH_OPND` when the hub answers; `PH_OPND`→`PH_RDX` for a lookup read, otherwise `PH_OPND`→`PH_GO`; `PH_RDX`→`PH_GO` always.

The decoder side of the core drives the operation inputs during the cycle in which `instr_valid` is high. The port presents the fetched word, its address and an alignment flag, and returns the operand and lookup-read data on the following clock.

Top module: `slot_mem_port`

## Requirements
- R1: With the default parameters, a PC from 0x000 to 0x7FF fetches register RAM word PC[10:2], a PC from 0x800 to 0xFFF fetches lookup RAM word PC[10:2], and a PC of 0x1000 or more fetches from the hub.
- R2: For a fetch from either local RAM, `instr_valid` rises on the second clock of the instruction and is never high on two clocks in a row.
- R3: A hub fetch raises `hub_req` with `hub_addr` equal to the PC with its two low bits cleared. Both hold steady until a clock with `hub_valid` high. The instruction word is then the `hub_rdata` sampled on that clock, and it is presented on the next clock.
- R4: No clock carries both a lookup-RAM instruction fetch and a lookup-RAM data access.
- R5: `op_kind` is 0 for no lookup access, 1 for a lookup read of word `op_laddr`, 2 for a write of `op_wdata` to word `op_laddr`, and 3 for no access. It is sampled while `instr_valid` is high. For a read, `lut_rd_valid` is high with the word on `lut_rd_data` on the clock after `instr_valid`, which makes the instruction three clocks long. For the other codes, `lut_rd_valid` stays low on that clock.
- R6: The source operand always comes from register RAM word `op_saddr`, whatever region the code runs from. `opnd_valid` and `opnd_data` present it on the clock after `instr_valid`.
- R7: After a lookup write, every later fetch of that location returns the new word. In particular, the instruction two after the writer sees it.
- R8: A PC whose two low bits are not zero sets `instr_misal` together with `instr_valid`. The fetch uses the address bits above those two bits. An aligned PC leaves `instr_misal` low.
- R9: While reset is held, `instr_valid`, `hub_req`, `opnd_valid` and `lut_rd_valid` are low. The first instruction after reset is fetched from PC 0x000.
- R10: On the last clock of each instruction, the PC becomes `jump_addr` if `jump_req` is high, and PC+4 otherwise.
- R11: A write through `reg_we`/`reg_waddr`/`reg_wdata` takes effect on any clock and is seen by later operand reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| jump_req | input | 1 | Load `jump_addr` into the PC at the end of the instruction |
| jump_addr | input | 20 | Branch target byte address |
| op_kind | input | 2 | Lookup-RAM data operation: 0 none, 1 read, 2 write, 3 none |
| op_laddr | input | 9 | Lookup-RAM word index for the data operation |
| op_wdata | input | 32 | Lookup-RAM write data |
| op_saddr | input | 9 | Register-RAM word index of the source operand |
| reg_we | input | 1 | Register-RAM result write enable |
| reg_waddr | input | 9 | Register-RAM result write index |
| reg_wdata | input | 32 | Register-RAM result write data |
| hub_req | output | 1 | Hub fetch request |
| hub_addr | output | 20 | Hub fetch byte address, word aligned |
| hub_valid | input | 1 | Hub response valid |
| hub_rdata | input | 32 | Hub response instruction word |
| instr_valid | output | 1 | Fetched instruction present (operand slot) |
| instr_pc | output | 20 | Byte address of the presented instruction |
| instr_word | output | 32 | Fetched instruction word |
| instr_misal | output | 1 | Presented instruction came from a misaligned PC |
| opnd_valid | output | 1 | Source operand present |
| opnd_data | output | 32 | Source operand word |
| lut_rd_valid | output | 1 | Lookup-RAM read data present (third clock) |
| lut_rd_data | output | 32 | Lookup-RAM read data |

## Verification
The bench builds the block with its default parameters: 512-word RAMs and a 20-bit PC. At these values, straight-line execution walks every word of the register region, then every word of the lookup region, and then crosses into the hub. Running that way fills the whole lookup RAM by data writes while executing from the register RAM. It then reads back a stride-7 permutation of the lookup RAM while executing from that same RAM, so the no-conflict interleaving is shown on every location. Further short jumps cover the region edges, write-to-fetch visibility, misaligned PCs and hub responses of several latencies.

// File: rtl/smp_pkg.sv
package smp_pkg;
    typedef enum logic [1:0] {
        PH_GO   = 2'd0,
        PH_OPND = 2'd1,
        PH_RDX  = 2'd2,
        PH_HUB  = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        RG_REG = 2'd0,
        RG_LUT = 2'd1,
        RG_HUB = 2'd2
    } region_e;

    localparam logic [1:0] OPK_LRD = 2'd1;
    localparam logic [1:0] OPK_LWR = 2'd2;
endpackage

// File: rtl/smp_sp_ram.sv
module smp_sp_ram #(
    parameter int DEPTH = 512,
    parameter int DW    = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          en,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (en) begin
            if (we) mem[addr] <= wdata;
            else    rdata     <= mem[addr];
        end
    end
endmodule

// File: rtl/smp_rw_ram.sv
module smp_rw_ram #(
    parameter int DEPTH = 512,
    parameter int DW    = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (re) rdata      <= mem[raddr];
        if (we) mem[waddr] <= wdata;
    end
endmodule

// File: rtl/smp_region_dec.sv
module smp_region_dec
    import smp_pkg::*;
#(
    parameter int PC_W  = 20,
    parameter int WORDS = 512,
    localparam int IDX_W = $clog2(WORDS),
    localparam int SPAN  = WORDS * 4
) (
    input  logic [PC_W-1:0]  pc,
    output region_e          region,
    output logic [IDX_W-1:0] idx,
    output logic             misal
);
    always_comb begin
        if (pc < PC_W'(SPAN))          region = RG_REG;
        else if (pc < PC_W'(2 * SPAN)) region = RG_LUT;
        else                           region = RG_HUB;
        idx   = pc[IDX_W+1:2];
        misal = |pc[1:0];
    end
endmodule

// File: rtl/smp_phase_seq.sv
module smp_phase_seq
    import smp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  region_e    region,
    input  logic [1:0] op_kind,
    input  logic       hub_valid,
    output logic       ph_go,
    output logic       reg_fetch_en,
    output logic       lut_fetch_en,
    output logic       lut_data_en,
    output logic       lut_we,
    output logic       hub_req,
    output logic       hub_cap,
    output logic       instr_slot,
    output logic       rd_slot,
    output logic       pc_step
);
    phase_e state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= PH_GO;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            PH_GO:   state_nx = (region == RG_HUB) ? PH_HUB : PH_OPND;
            PH_HUB:  state_nx = hub_valid ? PH_OPND : PH_HUB;
            PH_OPND: state_nx = (op_kind == OPK_LRD) ? PH_RDX : PH_GO;
            PH_RDX:  state_nx = PH_GO;
        endcase
    end

    always_comb begin
        ph_go        = 1'b0;
        reg_fetch_en = 1'b0;
        lut_fetch_en = 1'b0;
        lut_data_en  = 1'b0;
        lut_we       = 1'b0;
        hub_req      = 1'b0;
        hub_cap      = 1'b0;
        instr_slot   = 1'b0;
        rd_slot      = 1'b0;
        pc_step      = 1'b0;
        unique case (state)
            PH_GO: begin
                ph_go        = 1'b1;
                reg_fetch_en = (region == RG_REG);
                lut_fetch_en = (region == RG_LUT);
            end
            PH_HUB: begin
                hub_req = 1'b1;
                hub_cap = hub_valid;
            end
            PH_OPND: begin
                instr_slot  = 1'b1;
                lut_data_en = (op_kind == OPK_LRD) || (op_kind == OPK_LWR);
                lut_we      = (op_kind == OPK_LWR);
                pc_step     = (op_kind != OPK_LRD);
            end
            PH_RDX: begin
                rd_slot = 1'b1;
                pc_step = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/slot_mem_port.sv
module slot_mem_port
    import smp_pkg::*;
#(
    parameter int PC_W     = 20,
    parameter int DW       = 32,
    parameter int WORDS    = 512,
    parameter int RESET_PC = 0,
    localparam int IDX_W   = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             jump_req,
    input  logic [PC_W-1:0]  jump_addr,
    input  logic [1:0]       op_kind,
    input  logic [IDX_W-1:0] op_laddr,
    input  logic [DW-1:0]    op_wdata,
    input  logic [IDX_W-1:0] op_saddr,
    input  logic             reg_we,
    input  logic [IDX_W-1:0] reg_waddr,
    input  logic [DW-1:0]    reg_wdata,
    output logic             hub_req,
    output logic [PC_W-1:0]  hub_addr,
    input  logic             hub_valid,
    input  logic [DW-1:0]    hub_rdata,
    output logic             instr_valid,
    output logic [PC_W-1:0]  instr_pc,
    output logic [DW-1:0]    instr_word,
    output logic             instr_misal,
    output logic             opnd_valid,
    output logic [DW-1:0]    opnd_data,
    output logic             lut_rd_valid,
    output logic [DW-1:0]    lut_rd_data
);
    logic [PC_W-1:0]  pc_q;
    region_e          region, region_q;
    logic [IDX_W-1:0] pc_idx;
    logic             pc_misal;
    logic [DW-1:0]    hub_word_q;
    logic             opnd_vq;

    logic ph_go, reg_fetch_en, lut_fetch_en, lut_data_en, lut_we;
    logic hub_cap, instr_slot, rd_slot, pc_step;

    logic [DW-1:0]    reg_rdata, lut_rdata;
    logic             reg_re, lut_en;
    logic [IDX_W-1:0] reg_raddr, lut_addr;

    smp_region_dec #(.PC_W(PC_W), .WORDS(WORDS)) dec_i (
        .pc(pc_q), .region(region), .idx(pc_idx), .misal(pc_misal)
    );

    smp_phase_seq seq_i (
        .clk(clk), .rst_n(rst_n), .region(region), .op_kind(op_kind),
        .hub_valid(hub_valid), .ph_go(ph_go), .reg_fetch_en(reg_fetch_en),
        .lut_fetch_en(lut_fetch_en), .lut_data_en(lut_data_en), .lut_we(lut_we),
        .hub_req(hub_req), .hub_cap(hub_cap), .instr_slot(instr_slot),
        .rd_slot(rd_slot), .pc_step(pc_step)
    );

    // Register RAM: fetch read in the go slot, operand read in the operand slot.
    assign reg_re    = reg_fetch_en | instr_slot;
    assign reg_raddr = reg_fetch_en ? pc_idx : op_saddr;

    smp_rw_ram #(.DEPTH(WORDS), .DW(DW)) regram_i (
        .clk(clk), .re(reg_re), .raddr(reg_raddr), .rdata(reg_rdata),
        .we(reg_we), .waddr(reg_waddr), .wdata(reg_wdata)
    );

    // Lookup RAM: one port, owner chosen by phase.
    assign lut_en   = lut_fetch_en | lut_data_en;
    assign lut_addr = lut_fetch_en ? pc_idx : op_laddr;

    smp_sp_ram #(.DEPTH(WORDS), .DW(DW)) lutram_i (
        .clk(clk), .en(lut_en), .we(lut_we), .addr(lut_addr),
        .wdata(op_wdata), .rdata(lut_rdata)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q       <= PC_W'(RESET_PC);
            region_q   <= RG_REG;
            hub_word_q <= '0;
            opnd_vq    <= 1'b0;
        end else begin
            if (ph_go)   region_q   <= region;
            if (hub_cap) hub_word_q <= hub_rdata;
            if (pc_step) pc_q       <= jump_req ? jump_addr : pc_q + PC_W'(4);
            opnd_vq <= instr_slot;
        end
    end

    always_comb begin
        unique case (region_q)
            RG_REG:  instr_word = reg_rdata;
            RG_LUT:  instr_word = lut_rdata;
            default: instr_word = hub_word_q;
        endcase
    end

    assign hub_addr     = {pc_q[PC_W-1:2], 2'b00};
    assign instr_valid  = instr_slot;
    assign instr_pc     = pc_q;
    assign instr_misal  = instr_slot & pc_misal;
    assign opnd_valid   = opnd_vq;
    assign opnd_data    = reg_rdata;
    assign lut_rd_valid = rd_slot;
    assign lut_rd_data  = lut_rdata;
endmodule

// File: rtl/smp_checker.sv
module smp_checker #(
    parameter int PC_W  = 20,
    parameter int WORDS = 512
) (
    input logic            clk,
    input logic            rst_n,
    input logic            instr_valid,
    input logic            opnd_valid,
    input logic            lut_rd_valid,
    input logic [1:0]      op_kind,
    input logic            hub_req,
    input logic            hub_valid,
    input logic [PC_W-1:0] hub_addr,
    input logic [PC_W-1:0] instr_pc,
    input logic            lut_fetch_en,
    input logic            lut_data_en
);
    localparam logic [PC_W-1:0] LUT_LO = PC_W'(WORDS * 4);
    localparam logic [PC_W-1:0] LUT_HI = PC_W'(WORDS * 8);

    a_r4_phase_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(lut_fetch_en && lut_data_en));

    a_r1_lut_fetch_region: assert property (@(posedge clk) disable iff (!rst_n)
        lut_fetch_en |-> (instr_pc >= LUT_LO && instr_pc < LUT_HI));

    a_r2_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid |=> !instr_valid);

    a_r3_hub_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (hub_req && !hub_valid) |=> (hub_req && $stable(hub_addr)));

    a_r5_read_third_clock: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && op_kind == 2'd1) |=> lut_rd_valid);

    a_r5_no_read_no_data: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && op_kind != 2'd1) |=> !lut_rd_valid);

    a_r6_operand_follows: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid |=> opnd_valid);
endmodule

bind slot_mem_port smp_checker #(.PC_W(PC_W), .WORDS(WORDS)) chk_i (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .opnd_valid(opnd_valid),
    .lut_rd_valid(lut_rd_valid), .op_kind(op_kind), .hub_req(hub_req),
    .hub_valid(hub_valid), .hub_addr(hub_addr), .instr_pc(instr_pc),
    .lut_fetch_en(lut_fetch_en), .lut_data_en(lut_data_en)
);

// File: tb/slot_mem_port_tb.sv
module slot_mem_port_tb_top;
    localparam int PC_W = 20;
    localparam int DW   = 32;
    localparam int WORDS = 512;
    localparam int IW   = 9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic jump_req = 1'b0;
    logic [PC_W-1:0] jump_addr = '0;
    logic [1:0] op_kind = 2'd0;
    logic [IW-1:0] op_laddr = '0;
    logic [DW-1:0] op_wdata = '0;
    logic [IW-1:0] op_saddr = '0;
    logic reg_we = 1'b0;
    logic [IW-1:0] reg_waddr = '0;
    logic [DW-1:0] reg_wdata = '0;
    logic hub_req;
    logic [PC_W-1:0] hub_addr;
    logic hub_valid = 1'b0;
    logic [DW-1:0] hub_rdata = '0;
    logic instr_valid, instr_misal, opnd_valid, lut_rd_valid;
    logic [PC_W-1:0] instr_pc;
    logic [DW-1:0] instr_word, opnd_data, lut_rd_data;

    int errors = 0;
    int checks = 0;
    logic [DW-1:0] ref_reg [WORDS];
    logic [DW-1:0] ref_lut [WORDS];
    logic [PC_W-1:0] mpc = '0;
    int hub_cnt = 0;

    always #5 clk = ~clk;

    slot_mem_port dut_i (
        .clk(clk), .rst_n(rst_n), .jump_req(jump_req), .jump_addr(jump_addr),
        .op_kind(op_kind), .op_laddr(op_laddr), .op_wdata(op_wdata), .op_saddr(op_saddr),
        .reg_we(reg_we), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
        .hub_req(hub_req), .hub_addr(hub_addr), .hub_valid(hub_valid), .hub_rdata(hub_rdata),
        .instr_valid(instr_valid), .instr_pc(instr_pc), .instr_word(instr_word),
        .instr_misal(instr_misal), .opnd_valid(opnd_valid), .opnd_data(opnd_data),
        .lut_rd_valid(lut_rd_valid), .lut_rd_data(lut_rd_data)
    );

    function automatic logic [DW-1:0] ffun(int i);
        return 32'hC000_0000 | (32'(i) * 32'h0001_0003);
    endfunction
    function automatic logic [DW-1:0] gfun(int i);
        return 32'h5A00_0000 ^ (32'(i) * 32'h0007_0101);
    endfunction
    function automatic logic [DW-1:0] hfun(logic [PC_W-1:0] a);
        return 32'hB000_0000 | 32'(a);
    endfunction

    function automatic logic [DW-1:0] exp_word(logic [PC_W-1:0] pc);
        int idx = int'(pc[10:2]);
        if (pc < 20'h800)       return ref_reg[idx];
        else if (pc < 20'h1000) return ref_lut[idx];
        else                    return hfun({pc[PC_W-1:2], 2'b00});
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Hub responder: latency taken from hub address bits [3:2].
    always @(negedge clk) begin
        hub_valid = 1'b0;
        if (rst_n && hub_req) begin
            if (hub_cnt == int'(hub_addr[3:2])) begin
                hub_valid = 1'b1;
                hub_rdata = hfun(hub_addr);
                hub_cnt = 0;
            end else begin
                hub_cnt++;
            end
        end else begin
            hub_cnt = 0;
        end
    end

    task automatic run(input logic [1:0] kind, input int laddr, input logic [DW-1:0] wd,
                       input int saddr, input bit jmp, input logic [PC_W-1:0] jaddr);
        do @(negedge clk); while (!instr_valid);
        chk(instr_pc == mpc, "R10 pc sequence", DW'(instr_pc), DW'(mpc));
        chk(instr_word == exp_word(mpc), "R1/R3/R7 fetched word", instr_word, exp_word(mpc));
        chk(instr_misal == (|mpc[1:0]), "R8 misaligned flag", DW'(instr_misal), DW'(|mpc[1:0]));
        op_kind = kind; op_laddr = IW'(laddr); op_wdata = wd; op_saddr = IW'(saddr);
        jump_req = jmp; jump_addr = jaddr;
        @(negedge clk);
        chk(opnd_valid && opnd_data == ref_reg[saddr], "R6 operand from register RAM",
            opnd_data, ref_reg[saddr]);
        if (kind == 2'd1)
            chk(lut_rd_valid && lut_rd_data == ref_lut[laddr], "R5 lookup read third clock",
                lut_rd_data, ref_lut[laddr]);
        else
            chk(!lut_rd_valid, "R5 no read data without read", DW'(lut_rd_valid), 32'd0);
        chk(!instr_valid, "R2 two-clock rhythm", DW'(instr_valid), 32'd0);
        if (kind == 2'd2) ref_lut[laddr] = wd;
        op_kind = 2'd0;
        mpc = jmp ? jaddr : mpc + 20'd4;
    endtask

    initial begin
        // Preload register RAM while reset is held (R11: write on any clock).
        for (int i = 0; i < WORDS; i++) begin
            @(negedge clk);
            reg_we = 1'b1; reg_waddr = IW'(i); reg_wdata = ffun(i);
            ref_reg[i] = ffun(i);
        end
        @(negedge clk);
        reg_we = 1'b0;
        chk(!instr_valid && !hub_req && !opnd_valid && !lut_rd_valid, "R9 quiet in reset",
            {28'd0, instr_valid, hub_req, opnd_valid, lut_rd_valid}, 32'd0);
        rst_n = 1'b1;
        // R9/R1: run through the register region, filling the lookup RAM as data.
        for (int i = 0; i < WORDS; i++) run(2'd2, i, gfun(i), WORDS - 1 - i, 1'b0, '0);
        // R4/R5: run from the lookup RAM while reading it in stride-7 order.
        for (int i = 0; i < WORDS; i++) run(2'd1, (i * 7) % WORDS, '0, i, 1'b0, '0);
        // R3: hub region, latencies 0..3, then jump back into the lookup RAM.
        for (int i = 0; i < 5; i++) run(2'd3, 0, '0, i, i == 4, 20'h900);
        // R7: write-to-fetch visibility while executing from the lookup RAM.
        run(2'd2, 66, 32'hDEAD_BEEF, 3, 1'b0, '0);
        run(2'd0, 0, '0, 4, 1'b0, '0);
        run(2'd2, 68, 32'h1357_9BDF, 5, 1'b0, '0);
        run(2'd0, 0, '0, 6, 1'b0, '0);
        run(2'd1, 66, '0, 7, 1'b1, 20'h7FC);
        // R1 boundaries.
        run(2'd0, 0, '0, 8, 1'b0, '0);
        run(2'd0, 0, '0, 9, 1'b1, 20'hFFC);
        run(2'd0, 0, '0, 10, 1'b0, '0);
        run(2'd0, 0, '0, 11, 1'b1, 20'h80A);
        // R8: misaligned fetches, then back to an aligned PC.
        run(2'd0, 0, '0, 12, 1'b0, '0);
        run(2'd0, 0, '0, 13, 1'b1, 20'h004);
        // R11: result write at run time, read back as an operand.
        @(negedge clk);
        reg_we = 1'b1; reg_waddr = IW'(10); reg_wdata = 32'h0BAD_F00D;
        @(negedge clk);
        reg_we = 1'b0;
        ref_reg[10] = 32'h0BAD_F00D;
        run(2'd0, 0, '0, 10, 1'b0, '0);
        run(2'd0, 0, '0, 10, 1'b0, '0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule